// File: doc/BRIEF.md
# In-Place Path Metric Scheduler

This block sequences path-metric storage for a 64-state trellis processed by four butterflies, which together make eight add-compare-select units. Eight dual-port metric memories, each eight words deep, hold the metrics. Each memory is read at one address per cycle, so one trellis step (an iteration) takes eight cycles. The scheduler generates every memory's read address in each cycle. It delays those addresses to form the matching write addresses. It also routes the eight butterfly results to the memory write ports through two 4x4 permutation switches.

A new metric always returns to the word its predecessor was read from, so the whole trellis fits in 64 words (in-place updating). As a result, the mapping of states to addresses drifts from one iteration to the next. After six iterations it comes back to the starting layout. The read order inside an iteration is arranged so that the butterfly pipeline has at least five cycles between reading a word and needing its new value. Cycles 3 and 4 are swapped relative to the natural order to obtain that slack. The butterfly arithmetic sits outside this block. It receives the read data and hands its results back on `bf_res` exactly `WB_LAG` cycles after the read.

Top module: `pm_inplace_sched`

## Requirements
- R1: While reset is held, `rd_en` and `wr_en` are 0. The first read cycle after reset is cycle 0 of iteration 0: every memory reads address 0 and `rd_sel` is 00.
- R2: In iteration 0 every memory reads addresses 0, 1, 2, 4, 3, 5, 6, 7 in cycles 0 to 7.
- R3: In iteration n (0 to 5), read cycle c uses the logical index k, which is c with the values 3 and 4 exchanged. Memories 0 to 3 read k rotated left by (n mod 3) bits within 3 bits. Memories 4 to 7 read that value XOR a per-iteration offset of 0, 1, 3, 7, 6, 4 for n = 0 to 5. For example, iteration 1 reads 0, 2, 4, 1, 6, 3, 5, 7 in memories 0 to 3 and 1, 3, 5, 0, 7, 2, 4, 6 in memories 4 to 7.
- R4: Iterations count modulo 6, so the address pattern repeats every 48 read cycles.
- R5: The select code in read cycles 0 to 7 is 00, 01, 00, 10, 01, 11, 10, 11.
- R6: A read cycle at time t produces exactly one write cycle at time t+WB_LAG (default 4). In that cycle `wr_en` is 1, `wr_addr` equals the read addresses of cycle t and `wr_sel` equals the select code of cycle t. `wr_en` is 0 in all other cycles.
- R7: `bf_res` element 2*b+j is result j of butterfly b. Switch s (0 or 1) drives memory 2*q+s for port q = 0 to 3. That memory takes result j = q[1] XOR sel[0] of butterfly b = s + 2*(q[0] XOR sel[1]), using `wr_sel`.
- R8: While `run` is 0, no read is issued and the schedule position holds. When `run` returns to 1, reading resumes at the next position. Writes already in flight still drain.
- R9: No memory reads a word whose write-back is still pending or is being issued in the same cycle.
- R10: Within each iteration every memory reads each of its eight addresses exactly once, and each select code is used exactly twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Advance the schedule by one read cycle |
| bf_res | input | 8 x PM_W | Butterfly results, element 2*b+j |
| rd_en | output | 1 | Read strobe for all memories |
| rd_addr | output | 8 x 3 | Read address per memory |
| rd_sel | output | 2 | Select code of the current read cycle |
| wr_en | output | 1 | Write strobe for all memories |
| wr_addr | output | 8 x 3 | Write address per memory |
| wr_sel | output | 2 | Switch select code applied to the writes |
| wr_data | output | 8 x PM_W | Switched write data per memory |

## Verification
The hardest situation to reach is the tightest read-after-write spacing. A word written back in one iteration is read again only five cycles later, and these spacings shift when `run` drops in the middle of an iteration. The stimulus runs two full six-iteration periods without gaps. It then runs a stretch where `run` is low on every third cycle, and finally applies a reset in the middle of an iteration. Throughout, every read address is compared against all write-backs still queued in the scoreboard.

// File: rtl/pm_sched_pkg.sv
// Package: shared sizes, types and address-permutation helpers for the
// in-place path metric scheduler. Assumes 8 memories of depth 8.
package pm_sched_pkg;
    localparam int MEM_CNT     = 8;
    localparam int MEM_DEPTH   = 8;
    localparam int ADDR_W      = $clog2(MEM_DEPTH);
    localparam int BF_CNT      = MEM_CNT / 2;
    localparam int SW_CNT      = 2;
    localparam int SW_PORTS    = 4;
    localparam int SEL_W       = 2;
    localparam int ITER_PERIOD = 6;
    localparam int ITER_W      = $clog2(ITER_PERIOD);
    localparam int ROT_PERIOD  = ADDR_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [SEL_W-1:0]  sel_t;

    // Rotate a word address left by one bit.
    function automatic addr_t rotl1(addr_t v);
        return {v[ADDR_W-2:0], v[ADDR_W-1]};
    endfunction

    // Rotate a word address left by n bits (n below ROT_PERIOD).
    function automatic addr_t rotl_n(addr_t v, logic [ITER_W-1:0] n);
        addr_t r;
        r = v;
        for (int i = 0; i < ROT_PERIOD - 1; i++) begin
            if (ITER_W'(i) < n) r = rotl1(r);
        end
        return r;
    endfunction

    // Map a physical cycle to its logical slot: slots 3 and 4 trade places.
    function automatic addr_t phys_to_slot(addr_t c);
        addr_t k;
        case (c)
            addr_t'(3): k = addr_t'(4);
            addr_t'(4): k = addr_t'(3);
            default:    k = c;
        endcase
        return k;
    endfunction
endpackage

// File: rtl/pm_addr_gen.sv
// Read-side address generator. Keeps the cycle within the iteration, the
// iteration index modulo ITER_PERIOD and the XOR offset of the upper memory
// group, and derives each memory's read address and the select code.
// Assumes the caller holds 'go' low to stall; the position then freezes.
module pm_addr_gen
    import pm_sched_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           go,
    output logic [MEM_CNT-1:0][ADDR_W-1:0] rd_addr,
    output logic [SEL_W-1:0]               rd_sel
);
    addr_t             cyc_q;
    logic [ITER_W-1:0] iter_q;
    addr_t             xofs_q;
    logic [ITER_W-1:0] rot_amt;
    addr_t             slot;
    addr_t             base;

    // Advance cycle, iteration and group offset on each read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q  <= '0;
            iter_q <= '0;
            xofs_q <= '0;
        end else if (go) begin
            cyc_q <= cyc_q + addr_t'(1);
            if (cyc_q == addr_t'(MEM_DEPTH - 1)) begin
                xofs_q <= rotl1(xofs_q) ^ addr_t'(1);
                if (iter_q == ITER_W'(ITER_PERIOD - 1)) iter_q <= '0;
                else                                   iter_q <= iter_q + ITER_W'(1);
            end
        end
    end

    // Rotation amount is the iteration index modulo the address width.
    always_comb begin
        if (iter_q >= ITER_W'(ROT_PERIOD)) rot_amt = iter_q - ITER_W'(ROT_PERIOD);
        else                               rot_amt = iter_q;
        slot   = phys_to_slot(cyc_q);
        base   = rotl_n(slot, rot_amt);
        rd_sel = {slot[2], slot[0]};
    end

    // Lower half reads the rotated slot, upper half adds the XOR offset.
    for (genvar m = 0; m < MEM_CNT; m++) begin : g_addr
        if (m < MEM_CNT / 2) begin : g_lo
            assign rd_addr[m] = base;
        end else begin : g_hi
            assign rd_addr[m] = base ^ xofs_q;
        end
    end

    // Checker state: addresses seen and select codes used in this iteration.
    logic [MEM_CNT-1:0][MEM_DEPTH-1:0] seen_q;
    logic [3:0][1:0]                   selcnt_q;

    // Collect per-iteration usage for the assertions below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q   <= '0;
            selcnt_q <= '0;
        end else if (go) begin
            if (cyc_q == addr_t'(MEM_DEPTH - 1)) begin
                seen_q   <= '0;
                selcnt_q <= '0;
            end else begin
                for (int m = 0; m < MEM_CNT; m++) seen_q[m][rd_addr[m]] <= 1'b1;
                selcnt_q[rd_sel] <= selcnt_q[rd_sel] + 2'd1;
            end
        end
    end

    for (genvar m = 0; m < MEM_CNT; m++) begin : g_chk
        AST_ADDR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
            go |-> !seen_q[m][rd_addr[m]]); // R10
    end

    AST_SEL_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (selcnt_q[rd_sel] < 2'd2)); // R10

    AST_PERIOD_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (go && cyc_q == '0 && iter_q == '0) |-> (xofs_q == '0)); // R4
endmodule

// File: rtl/pm_wb_delay.sv
// Write-back delay line. Carries the read strobe, per-memory addresses and
// select code through WB_LAG register stages so writes land on the words
// that were read. Assumes WB_LAG is at least 1 and small.
module pm_wb_delay
    import pm_sched_pkg::*;
#(
    parameter int WB_LAG = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en,
    input  logic [MEM_CNT-1:0][ADDR_W-1:0] rd_addr,
    input  logic [SEL_W-1:0]               rd_sel,
    output logic                           wr_en,
    output logic [MEM_CNT-1:0][ADDR_W-1:0] wr_addr,
    output logic [SEL_W-1:0]               wr_sel
);
    logic [WB_LAG:1]                           st_en;
    logic [WB_LAG:1][MEM_CNT-1:0][ADDR_W-1:0]  st_addr;
    logic [WB_LAG:1][SEL_W-1:0]                st_sel;

    // Shift the read-side controls one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_en   <= '0;
            st_addr <= '0;
            st_sel  <= '0;
        end else begin
            st_en[1]   <= rd_en;
            st_addr[1] <= rd_addr;
            st_sel[1]  <= rd_sel;
            for (int j = 2; j <= WB_LAG; j++) begin
                st_en[j]   <= st_en[j-1];
                st_addr[j] <= st_addr[j-1];
                st_sel[j]  <= st_sel[j-1];
            end
        end
    end

    assign wr_en   = st_en[WB_LAG];
    assign wr_addr = st_addr[WB_LAG];
    assign wr_sel  = st_sel[WB_LAG];

    // No read may hit a word whose write is in flight or issued now.
    for (genvar j = 1; j <= WB_LAG; j++) begin : g_stage
        for (genvar m = 0; m < MEM_CNT; m++) begin : g_mem
            AST_NO_EARLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en && st_en[j]) |-> (rd_addr[m] != st_addr[j][m])); // R9
        end
    end
endmodule

// File: rtl/pm_perm_switch.sv
// One 4x4 permutation switch. Port q takes result q[1]^sel[0] of the
// butterfly picked by q[0]^sel[1] (0 = lo, 1 = hi). Purely combinational.
module pm_perm_switch
    import pm_sched_pkg::*;
#(
    parameter int PM_W = 6
) (
    input  logic [1:0][PM_W-1:0]          lo_res,
    input  logic [1:0][PM_W-1:0]          hi_res,
    input  logic [SEL_W-1:0]              sel,
    output logic [SW_PORTS-1:0][PM_W-1:0] port_q
);
    // Route each output port from its selected butterfly result.
    always_comb begin
        for (int q = 0; q < SW_PORTS; q++) begin
            logic pick_hi;
            logic pick_j;
            pick_hi = q[0] ^ sel[1];
            pick_j  = q[1] ^ sel[0];
            port_q[q] = pick_hi ? hi_res[pick_j] : lo_res[pick_j];
        end
    end
endmodule

// File: rtl/pm_inplace_sched.sv
// Top of the in-place path metric scheduler: read address generation,
// write-back delay and the two write-side permutation switches. Assumes the
// butterfly pipeline returns results exactly WB_LAG cycles after the read.
module pm_inplace_sched
    import pm_sched_pkg::*;
#(
    parameter int PM_W   = 6,
    parameter int WB_LAG = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            run,
    input  logic [2*BF_CNT-1:0][PM_W-1:0]   bf_res,
    output logic                            rd_en,
    output logic [MEM_CNT-1:0][ADDR_W-1:0]  rd_addr,
    output logic [SEL_W-1:0]                rd_sel,
    output logic                            wr_en,
    output logic [MEM_CNT-1:0][ADDR_W-1:0]  wr_addr,
    output logic [SEL_W-1:0]                wr_sel,
    output logic [MEM_CNT-1:0][PM_W-1:0]    wr_data
);
    logic go;
    assign go    = run & rst_n;
    assign rd_en = go;

    pm_addr_gen u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .rd_addr (rd_addr),
        .rd_sel  (rd_sel)
    );

    pm_wb_delay #(.WB_LAG(WB_LAG)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (go),
        .rd_addr (rd_addr),
        .rd_sel  (rd_sel),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_sel  (wr_sel)
    );

    // Switch s pairs butterflies s and s+2 and feeds memories 2q+s.
    for (genvar s = 0; s < SW_CNT; s++) begin : g_sw
        logic [SW_PORTS-1:0][PM_W-1:0] sw_out;
        pm_perm_switch #(.PM_W(PM_W)) u_sw (
            .lo_res ({bf_res[2*s+1],     bf_res[2*s]}),
            .hi_res ({bf_res[2*(s+2)+1], bf_res[2*(s+2)]}),
            .sel    (wr_sel),
            .port_q (sw_out)
        );
        for (genvar q = 0; q < SW_PORTS; q++) begin : g_port
            assign wr_data[2*q+s] = sw_out[q];
        end
    end

    AST_WR_QUIET_IN_RESET: assert property (@(posedge clk)
        !rst_n |=> !wr_en); // R1
endmodule

// File: tb/pm_inplace_sched_bench.sv
// Scoreboard bench: the driver checks the read side and queues expected
// write-backs; the monitor pops and compares them when the writes appear.
module pm_inplace_sched_bench;
    import pm_sched_pkg::*;
    localparam int PM_W   = 6;
    localparam int WB_LAG = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic [2*BF_CNT-1:0][PM_W-1:0]  bf_res = '0;
    logic                           rd_en, wr_en;
    logic [MEM_CNT-1:0][ADDR_W-1:0] rd_addr, wr_addr;
    logic [SEL_W-1:0]               rd_sel, wr_sel;
    logic [MEM_CNT-1:0][PM_W-1:0]   wr_data;

    pm_inplace_sched #(.PM_W(PM_W), .WB_LAG(WB_LAG)) u_pm_inplace_sched (
        .clk(clk), .rst_n(rst_n), .run(run), .bf_res(bf_res),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_sel(rd_sel),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_sel(wr_sel), .wr_data(wr_data)
    );

    always #5 clk = ~clk;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    int unsigned tcyc  = 0;
    bit          done  = 0;
    always @(posedge clk) tcyc <= tcyc + 1;

    typedef struct {
        int unsigned                    due;
        logic [MEM_CNT-1:0][ADDR_W-1:0] addr;
        logic [SEL_W-1:0]               sel;
    } wr_item_t;
    wr_item_t exp_q[$];

    int m_cyc = 0;
    int m_iter = 0;
    int m_total = 0;
    int seen [MEM_CNT];
    int selc [4];
    int sel_seq [8]  = '{0, 1, 0, 2, 1, 3, 2, 3};
    int ofs_tab [6]  = '{0, 1, 3, 7, 6, 4};
    int it0 [8]      = '{0, 1, 2, 4, 3, 5, 6, 7};
    int it1lo [8]    = '{0, 2, 4, 1, 6, 3, 5, 7};
    int it1hi [8]    = '{1, 3, 5, 0, 7, 2, 4, 6};

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_addr(int iter, int c, int m);
        int k, r;
        k = (c == 3) ? 4 : (c == 4) ? 3 : c;
        for (int i = 0; i < iter % 3; i++) k = ((k << 1) | (k >> 2)) & 7;
        if (m >= MEM_CNT / 2) k = k ^ ofs_tab[iter];
        return k;
    endfunction

    task automatic clear_usage();
        for (int m = 0; m < MEM_CNT; m++) seen[m] = 0;
        for (int s = 0; s < 4; s++) selc[s] = 0;
    endtask

    // Driver: apply one cycle of stimulus and check the read side.
    task automatic drive_cycle(input bit r);
        @(negedge clk);
        run = r;
        for (int i = 0; i < 2 * BF_CNT; i++) bf_res[i] = PM_W'(tcyc * 8 + i * 5 + 3);
        #2;
        chk(rd_en == r, r ? "R6" : "R8", "rd_en", int'(rd_en), int'(r));
        if (r) begin
            wr_item_t it;
            if (m_total == 0) begin
                chk(rd_addr == '0 && rd_sel == '0, "R1", "first read addr/sel",
                    int'(rd_addr), 0);
            end
            for (int m = 0; m < MEM_CNT; m++) begin
                chk(int'(rd_addr[m]) == exp_addr(m_iter, m_cyc, m), "R3", "rd_addr",
                    int'(rd_addr[m]), exp_addr(m_iter, m_cyc, m));
                if (m_iter == 0)
                    chk(int'(rd_addr[m]) == it0[m_cyc], "R2", "iteration 0 addr",
                        int'(rd_addr[m]), it0[m_cyc]);
                if (m_iter == 1)
                    chk(int'(rd_addr[m]) == ((m < 4) ? it1lo[m_cyc] : it1hi[m_cyc]),
                        "R3", "iteration 1 addr", int'(rd_addr[m]),
                        (m < 4) ? it1lo[m_cyc] : it1hi[m_cyc]);
                foreach (exp_q[e]) begin
                    if (exp_q[e].due >= tcyc)
                        chk(rd_addr[m] != exp_q[e].addr[m], "R9", "read of pending word",
                            int'(rd_addr[m]), -1);
                end
                seen[m] = seen[m] | (1 << rd_addr[m]);
            end
            chk(int'(rd_sel) == sel_seq[m_cyc], "R5", "rd_sel", int'(rd_sel), sel_seq[m_cyc]);
            selc[rd_sel]++;
            it.due  = tcyc + WB_LAG;
            it.addr = rd_addr;
            it.sel  = rd_sel;
            exp_q.push_back(it);
            m_total++;
            if (m_cyc == 7) begin
                for (int m = 0; m < MEM_CNT; m++)
                    chk(seen[m] == 255, "R10", "address coverage", seen[m], 255);
                for (int s = 0; s < 4; s++)
                    chk(selc[s] == 2, "R10", "select use count", selc[s], 2);
                clear_usage();
                m_cyc = 0;
                m_iter = (m_iter + 1) % 6;
                if (m_iter == 0)
                    chk(m_total % 48 == 0, "R4", "period wrap point", m_total % 48, 0);
            end else begin
                m_cyc++;
            end
        end
    endtask

    // Monitor: compare writes against the queued expectations.
    always @(negedge clk) begin
        #3;
        if (rst_n && !done) begin
            if (exp_q.size() > 0 && exp_q[0].due == tcyc) begin
                wr_item_t it;
                it = exp_q.pop_front();
                chk(wr_en == 1'b1, "R6", "wr_en due", int'(wr_en), 1);
                chk(wr_addr == it.addr, "R6", "wr_addr", int'(wr_addr), int'(it.addr));
                chk(wr_sel == it.sel, "R6", "wr_sel", int'(wr_sel), int'(it.sel));
                for (int i = 0; i < MEM_CNT; i++) begin
                    int s, q, b, j;
                    s = i % 2;
                    q = i / 2;
                    b = s + 2 * ((q & 1) ^ int'(it.sel[1]));
                    j = ((q >> 1) & 1) ^ int'(it.sel[0]);
                    chk(wr_data[i] == bf_res[2 * b + j], "R7", "wr_data routing",
                        int'(wr_data[i]), int'(bf_res[2 * b + j]));
                end
            end else begin
                chk(wr_en == 1'b0, "R6", "wr_en idle", int'(wr_en), 0);
            end
        end
    end

    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst_n = 1'b0;
        run = 1'b0;
        exp_q.delete();
        m_cyc = 0;
        m_iter = 0;
        m_total = 0;
        clear_usage();
        repeat (cycles) @(negedge clk);
        #2;
        chk(rd_en == 1'b0, "R1", "rd_en in reset", int'(rd_en), 0);
        chk(wr_en == 1'b0, "R1", "wr_en in reset", int'(wr_en), 0);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        clear_usage();
        do_reset(3);
        // Two full periods without gaps (R2, R3, R4, R5).
        for (int i = 0; i < 100; i++) drive_cycle(1'b1);
        // Stalls on every third cycle (R8, R9).
        for (int i = 0; i < 72; i++) drive_cycle(i % 3 != 1);
        // Reset in the middle of an iteration, then restart (R1).
        for (int i = 0; i < 3; i++) drive_cycle(1'b1);
        do_reset(2);
        for (int i = 0; i < 21; i++) drive_cycle(1'b1);
        // Drain the write-backs with run low (R8, R6).
        for (int i = 0; i < 10; i++) drive_cycle(1'b0);
        chk(exp_q.size() == 0, "R6", "writes left undrained", exp_q.size(), 0);
        finish_run();
    end
endmodule